// File: doc/BRIEF.md
# Two-dimensional DMA address generator

This block is the address sequencer of one DMA channel. Software loads a word-granular start address, a line length, a line stride and a line count, then pulses `start`. The sequencer walks a rectangular region: each line covers `cfg_line_len` consecutive 32-bit words, and each new line begins `cfg_stride` words after the start of the line before it. Each word address is offered on a valid/ready handshake. A downstream bus engine consumes the addresses and moves the data, so it sees the transfer direction and burst flag next to each address. All quantities count words, so the start address is a byte address shifted right by two.

A line length of zero turns the block into a ring walker. It steps linearly through `cfg_stride * (cfg_lines_m1 + 1)` words and returns to the start address at the end of the area. It raises one pulse when the first half of the ring is consumed and another when the second half is consumed. The ring runs until `stop`. With the burst bit set, one address stands for four words, so the sequencer advances by four words per handshake.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset `req_valid`, `busy`, `done`, `evt_half_a` and `evt_half_b` are all 0.
- R2: A `start` pulse while idle with `stop` low captures all configuration inputs, and `req_valid` is 1 in the next cycle. A `start` while busy is ignored: the running sequence and its captured configuration are unchanged.
- R3: With a non-zero line length and the burst bit 0, the offered addresses are `base + k*stride + j` for line k from 0 and word j from 0 to `line_len-1`, in order of k then j, modulo 2^AW.
- R4: The number of lines is `cfg_lines_m1 + 1`; a value of 0 gives exactly one line.
- R5: With the burst bit 1 (the line length must then be a multiple of 4), one address is offered per 4 words, at j = 0, 4, 8 and so on, and `req_burst4` is 1.
- R6: While `req_valid` is 1 and `req_ready` is 0 (and `stop` is low), the address and valid hold in the next cycle.
- R7: In line mode, `done` pulses for one cycle in the cycle after the last address is accepted. `busy` and `req_valid` are 0 in that same cycle.
- R8: A line length of 0 selects ring mode. The offered addresses are `base + i`, with i stepping by 1 (or by 4 in burst mode) through 0 to `area-1`, where `area = stride*(lines_m1+1)`. After the last one the sequence returns to i = 0. `done` never pulses in ring mode.
- R9: In ring mode, `evt_half_a` pulses in the cycle after acceptance of the beat that ends at word offset `area/2`. `evt_half_b` pulses in the cycle after acceptance of the beat that ends the area. At most one of `done`, `evt_half_a` and `evt_half_b` is 1 in any cycle.
- R10: `stop` while busy returns the block to idle in the next cycle with no `done` and no event pulse. A beat offered in the stop cycle counts as not taken. `stop` also blocks a `start` given in the same cycle.
- R11: `req_to_dev` equals the captured direction bit (1 memory-to-device, 0 device-to-memory) for every offered address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load configuration and begin (idle only) |
| stop | input | 1 | Abort the sequence and return to idle |
| cfg_base | input | AW | Start word address |
| cfg_line_len | input | LEN_W | Words per line; 0 selects ring mode |
| cfg_stride | input | STRIDE_W | Words between line starts (ring: words per line of the area) |
| cfg_lines_m1 | input | LINES_W | Line count minus one |
| cfg_to_dev | input | 1 | Direction: 1 memory-to-device, 0 device-to-memory |
| cfg_burst4 | input | 1 | 1: one address per 4-word burst |
| req_valid | output | 1 | Address offered |
| req_ready | input | 1 | Address taken by the bus engine |
| req_addr | output | AW | Word address |
| req_to_dev | output | 1 | Captured direction |
| req_burst4 | output | 1 | Captured burst flag |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle pulse: line-mode sequence complete |
| evt_half_a | output | 1 | One-cycle pulse: first ring half consumed |
| evt_half_b | output | 1 | One-cycle pulse: second ring half consumed |

## Verification
Line mode is swept over line lengths of 1, 2, 3 and 5 words, over strides equal to and larger than the line, over one, two and four lines, and over both directions. Each of these runs once with a constantly ready consumer and once with a stalling one. The sweep separates the word counter from the line counter and shows that the stride applies to line starts only. It also shows that stalls neither skip nor repeat a beat. Burst runs with lines of 4 and 8 words show that addresses are offered only on 4-word boundaries. Ring runs with even and odd half sizes, a burst ring, and a base near the top of the address space check the wrap point, the placement of both half events over several passes, and address wrap. Abort runs, and a start given in mid-run, show that stop gives no done pulse and that a late start changes nothing.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  localparam int unsigned BURST_BEATS = 4;

  // words covered by one accepted address
  function automatic logic [31:0] beat_step(input logic burst4);
    return burst4 ? 32'(BURST_BEATS) : 32'd1;
  endfunction

  // size of the ring in words
  function automatic logic [31:0] area_words(input logic [31:0] stride,
                                             input logic [31:0] lines_m1);
    return stride * (lines_m1 + 32'd1);
  endfunction

  // offset at which the first half of the ring ends
  function automatic logic [31:0] half_words(input logic [31:0] area);
    return area >> 1;
  endfunction

endpackage

// File: rtl/dma2d_cfg_hold.sv
module dma2d_cfg_hold
  import dma2d_pkg::*;
#(
  parameter int AW       = 30,
  parameter int LEN_W    = 12,
  parameter int STRIDE_W = 12,
  parameter int LINES_W  = 12,
  parameter int ARW      = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [AW-1:0]       cfg_base,
  input  logic [LEN_W-1:0]    cfg_line_len,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [LINES_W-1:0]  cfg_lines_m1,
  input  logic                cfg_to_dev,
  input  logic                cfg_burst4,
  output logic [AW-1:0]       base_q,
  output logic [LEN_W-1:0]    len_q,
  output logic [STRIDE_W-1:0] stride_q,
  output logic [LINES_W-1:0]  lines_q,
  output logic                to_dev_q,
  output logic                burst_q,
  output logic                loop_q,
  output logic [ARW-1:0]      area_q,
  output logic [ARW-1:0]      half_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      len_q    <= '0;
      stride_q <= '0;
      lines_q  <= '0;
      to_dev_q <= 1'b0;
      burst_q  <= 1'b0;
      loop_q   <= 1'b0;
      area_q   <= '0;
      half_q   <= '0;
    end else if (load) begin
      base_q   <= cfg_base;
      len_q    <= cfg_line_len;
      stride_q <= cfg_stride;
      lines_q  <= cfg_lines_m1;
      to_dev_q <= cfg_to_dev;
      burst_q  <= cfg_burst4;
      loop_q   <= (cfg_line_len == '0);
      // ring size is computed once here, off the per-beat path
      area_q   <= ARW'(area_words(32'(cfg_stride), 32'(cfg_lines_m1)));
      half_q   <= ARW'(half_words(area_words(32'(cfg_stride), 32'(cfg_lines_m1))));
    end
  end

endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
#(
  parameter int AW       = 30,
  parameter int LEN_W    = 12,
  parameter int STRIDE_W = 12,
  parameter int LINES_W  = 12,
  parameter int ARW      = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                adv,
  input  logic [AW-1:0]       base_q,
  input  logic [LEN_W-1:0]    len_q,
  input  logic [STRIDE_W-1:0] stride_q,
  input  logic [LINES_W-1:0]  lines_q,
  input  logic                loop_q,
  input  logic                burst_q,
  input  logic [ARW-1:0]      area_q,
  input  logic [ARW-1:0]      half_q,
  output logic [AW-1:0]       cur_addr,
  output logic                last_beat,
  output logic                hit_half,
  output logic                hit_end,
  output logic [1:0]          x_phase
);

  logic [LEN_W-1:0]   x_off;
  logic [LINES_W-1:0] y_cnt;
  logic [AW-1:0]      line_off;
  logic [ARW-1:0]     ring_off;
  logic [LEN_W:0]     x_next;
  logic [ARW:0]       r_next;
  logic               line_end;

  always_comb begin
    x_next    = {1'b0, x_off} + (LEN_W+1)'(beat_step(burst_q));
    line_end  = (x_next >= {1'b0, len_q});
    r_next    = {1'b0, ring_off} + (ARW+1)'(beat_step(burst_q));
    hit_half  = loop_q && (r_next == {1'b0, half_q});
    hit_end   = loop_q && (r_next >= {1'b0, area_q});
    last_beat = !loop_q && line_end && (y_cnt == lines_q);
    if (loop_q) cur_addr = base_q + AW'(ring_off);
    else        cur_addr = base_q + line_off + AW'(x_off);
  end

  generate
    if (LEN_W >= 2) begin : g_phase_wide
      assign x_phase = x_off[1:0];
    end else begin : g_phase_narrow
      assign x_phase = {1'b0, x_off[0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_off    <= '0;
      y_cnt    <= '0;
      line_off <= '0;
      ring_off <= '0;
    end else if (load) begin
      x_off    <= '0;
      y_cnt    <= '0;
      line_off <= '0;
      ring_off <= '0;
    end else if (adv) begin
      if (loop_q) begin
        ring_off <= hit_end ? '0 : r_next[ARW-1:0];
      end else if (line_end) begin
        x_off    <= '0;
        y_cnt    <= y_cnt + 1'b1;
        line_off <= line_off + AW'(stride_q);
      end else begin
        x_off <= x_next[LEN_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic req_ready,
  input  logic last_beat,
  input  logic hit_half,
  input  logic hit_end,
  output logic load,
  output logic adv,
  output logic run,
  output logic done_q,
  output logic evt_a_q,
  output logic evt_b_q
);

  run_state_e st;

  assign run  = (st == ST_RUN);
  assign load = start && !run && !stop;
  assign adv  = run && req_ready && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      done_q  <= 1'b0;
      evt_a_q <= 1'b0;
      evt_b_q <= 1'b0;
    end else begin
      done_q  <= adv && last_beat;
      evt_a_q <= adv && hit_half;
      evt_b_q <= adv && hit_end;
      case (st)
        ST_IDLE: if (load) st <= ST_RUN;
        ST_RUN:  if (stop || (adv && last_beat)) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW       = 30,
  parameter int LEN_W    = 12,
  parameter int STRIDE_W = 12,
  parameter int LINES_W  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                stop,
  input  logic [AW-1:0]       cfg_base,
  input  logic [LEN_W-1:0]    cfg_line_len,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [LINES_W-1:0]  cfg_lines_m1,
  input  logic                cfg_to_dev,
  input  logic                cfg_burst4,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_addr,
  output logic                req_to_dev,
  output logic                req_burst4,
  output logic                busy,
  output logic                done,
  output logic                evt_half_a,
  output logic                evt_half_b
);

  localparam int ARW = STRIDE_W + LINES_W + 1;

  // named internal events, visible to the bound checker
  logic                load;
  logic                adv;
  logic                run;
  logic                last_beat;
  logic                hit_half;
  logic                hit_end;
  logic                loop_mode;
  logic [1:0]          x_phase;
  logic [AW-1:0]       base_q;
  logic [LEN_W-1:0]    len_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [LINES_W-1:0]  lines_q;
  logic [ARW-1:0]      area_q;
  logic [ARW-1:0]      half_q;

  dma2d_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .req_ready (req_ready),
    .last_beat (last_beat),
    .hit_half  (hit_half),
    .hit_end   (hit_end),
    .load      (load),
    .adv       (adv),
    .run       (run),
    .done_q    (done),
    .evt_a_q   (evt_half_a),
    .evt_b_q   (evt_half_b)
  );

  dma2d_cfg_hold #(
    .AW(AW), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W), .LINES_W(LINES_W), .ARW(ARW)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .cfg_base     (cfg_base),
    .cfg_line_len (cfg_line_len),
    .cfg_stride   (cfg_stride),
    .cfg_lines_m1 (cfg_lines_m1),
    .cfg_to_dev   (cfg_to_dev),
    .cfg_burst4   (cfg_burst4),
    .base_q       (base_q),
    .len_q        (len_q),
    .stride_q     (stride_q),
    .lines_q      (lines_q),
    .to_dev_q     (req_to_dev),
    .burst_q      (req_burst4),
    .loop_q       (loop_mode),
    .area_q       (area_q),
    .half_q       (half_q)
  );

  dma2d_walker #(
    .AW(AW), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W), .LINES_W(LINES_W), .ARW(ARW)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .adv       (adv),
    .base_q    (base_q),
    .len_q     (len_q),
    .stride_q  (stride_q),
    .lines_q   (lines_q),
    .loop_q    (loop_mode),
    .burst_q   (req_burst4),
    .area_q    (area_q),
    .half_q    (half_q),
    .cur_addr  (req_addr),
    .last_beat (last_beat),
    .hit_half  (hit_half),
    .hit_end   (hit_end),
    .x_phase   (x_phase)
  );

  assign req_valid = run;
  assign busy      = run;

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stop,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          busy,
  input logic          done,
  input logic          evt_half_a,
  input logic          evt_half_b,
  input logic          loop_mode,
  input logic          burst_mode,
  input logic [1:0]    x_phase
);

  AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !stop |=> req_valid); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !stop |=> req_valid && $stable(req_addr)); // R6

  AST_BURST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && burst_mode && !loop_mode |-> x_phase == 2'b00); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !loop_mode); // R7

  AST_EVT_LOOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_half_a || evt_half_b) |-> loop_mode); // R9

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, evt_half_a, evt_half_b})); // R9

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !req_valid && !done && !evt_half_a && !evt_half_b); // R10

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .stop       (stop),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .busy       (busy),
  .done       (done),
  .evt_half_a (evt_half_a),
  .evt_half_b (evt_half_b),
  .loop_mode  (loop_mode),
  .burst_mode (req_burst4),
  .x_phase    (x_phase)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb_top;

  localparam int AW = 16, LEN_W = 6, STRIDE_W = 6, LINES_W = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic                stop = 1'b0;
  logic [AW-1:0]       cfg_base = '0;
  logic [LEN_W-1:0]    cfg_line_len = '0;
  logic [STRIDE_W-1:0] cfg_stride = '0;
  logic [LINES_W-1:0]  cfg_lines_m1 = '0;
  logic                cfg_to_dev = 1'b0;
  logic                cfg_burst4 = 1'b0;
  logic                req_ready = 1'b0;
  logic                req_valid, req_to_dev, req_burst4, busy, done, evt_half_a, evt_half_b;
  logic [AW-1:0]       req_addr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] lfsr = 8'hA5;
  bit stall_mode = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dma2d_addr_gen #(.AW(AW), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W), .LINES_W(LINES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cfg_base(cfg_base), .cfg_line_len(cfg_line_len), .cfg_stride(cfg_stride),
    .cfg_lines_m1(cfg_lines_m1), .cfg_to_dev(cfg_to_dev), .cfg_burst4(cfg_burst4),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_to_dev(req_to_dev), .req_burst4(req_burst4), .busy(busy), .done(done),
    .evt_half_a(evt_half_a), .evt_half_b(evt_half_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic pick_ready();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic load_cfg(input int base, input int len, input int stride, input int lm1,
                          input bit dir, input bit burst);
    cfg_base     = AW'(base);
    cfg_line_len = LEN_W'(len);
    cfg_stride   = STRIDE_W'(stride);
    cfg_lines_m1 = LINES_W'(lm1);
    cfg_to_dev   = dir;
    cfg_burst4   = burst;
    start        = 1'b1;
    @(negedge clk);
    start        = 1'b0;
  endtask

  // line mode; abort_at>=0 issues stop after that many beats, poke pulses start mid-run
  task automatic run_lines(input int base, input int len, input int stride, input int lm1,
                           input bit dir, input bit burst, input bit poke, input int abort_at);
    int j = 0, k = 0, beats = 0, step = burst ? 4 : 1, guard = 0;
    bit fin = 1'b0;
    logic [AW-1:0] e;
    load_cfg(base, len, stride, lm1, dir, burst);
    chk(req_valid == 1'b1 && busy == 1'b1, "R2 start", req_valid, 1);
    while (!fin && guard < 3000) begin
      if (abort_at >= 0 && beats == abort_at) begin
        stop = 1'b1; req_ready = 1'b1;
        @(negedge clk);
        stop = 1'b0; req_ready = 1'b0;
        chk(req_valid == 1'b0 && busy == 1'b0, "R10 stop idle", req_valid, 0);
        chk(done == 1'b0, "R10 no done", done, 0);
        @(negedge clk);
        chk(done == 1'b0 && req_valid == 1'b0, "R10 stays idle", done, 0);
        return;
      end
      start = (poke && beats == 2) ? 1'b1 : 1'b0;
      if (poke && beats == 2) cfg_base = cfg_base + AW'(7);
      req_ready = pick_ready();
      if (req_valid && req_ready) begin
        e = AW'(base + k * stride + j);
        chk(req_addr == e, burst ? "R5 burst addr" : "R3 addr", req_addr, e);
        chk(req_to_dev == dir, "R11 dir", req_to_dev, dir);
        chk(req_burst4 == burst, "R5 burst flag", req_burst4, burst);
        beats++;
        j += step;
        if (j >= len) begin
          j = 0; k++;
          if (k > lm1) fin = 1'b1;
        end
      end
      @(negedge clk);
      start = 1'b0;
      guard++;
      if (!fin) chk(done == 1'b0 && req_valid == 1'b1, "R7 no early done", done, 0);
    end
    req_ready = 1'b0;
    chk(done == 1'b1, "R7 done pulse", done, 1);
    chk(busy == 1'b0 && req_valid == 1'b0, "R4 line count ends", busy, 0);
    chk(k == lm1 + 1, "R4 lines", k, lm1 + 1);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
  endtask

  task automatic run_ring(input int base, input int stride, input int lm1, input bit burst,
                          input int passes);
    int area = stride * (lm1 + 1), half = area / 2, step = burst ? 4 : 1;
    int i = 0, cnt = 0, nxt, target = passes * area / step, na = 0, nb = 0, guard = 0;
    bit pa = 1'b0, pb = 1'b0;
    logic [AW-1:0] e;
    load_cfg(base, 0, stride, lm1, 1'b0, burst);
    chk(req_valid == 1'b1, "R8 ring start", req_valid, 1);
    while (cnt < target && guard < 5000) begin
      chk(evt_half_a == pa, "R9 first half event", evt_half_a, pa);
      chk(evt_half_b == pb, "R9 second half event", evt_half_b, pb);
      chk(done == 1'b0, "R8 no done in ring", done, 0);
      pa = 1'b0; pb = 1'b0;
      req_ready = pick_ready();
      if (req_valid && req_ready) begin
        e = AW'(base + i);
        chk(req_addr == e, "R8 ring addr", req_addr, e);
        nxt = i + step;
        pa = (nxt == half);
        pb = (nxt >= area);
        na += int'(pa); nb += int'(pb);
        i = pb ? 0 : nxt;
        cnt++;
      end
      @(negedge clk);
      guard++;
    end
    chk(evt_half_a == pa && evt_half_b == pb, "R9 last event", {evt_half_a, evt_half_b}, {pa, pb});
    chk(na == passes && nb == passes, "R9 two events per pass", na + nb, 2 * passes);
    stop = 1'b1; req_ready = 1'b0;
    @(negedge clk);
    stop = 1'b0;
    chk(req_valid == 1'b0 && busy == 1'b0, "R10 ring stop", req_valid, 0);
    chk(done == 1'b0 && evt_half_a == 1'b0 && evt_half_b == 1'b0, "R10 ring stop quiet", done, 0);
    @(negedge clk);
  endtask

  initial begin
    int lens[4] = '{1, 2, 3, 5};
    int lms[3]  = '{0, 1, 3};
    #1;
    chk(req_valid == 1'b0 && busy == 1'b0, "R1 reset valid", req_valid, 0);
    chk(done == 1'b0 && evt_half_a == 1'b0 && evt_half_b == 1'b0, "R1 reset pulses", done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0 && busy == 1'b0, "R1 idle after reset", busy, 0);

    for (int sm = 0; sm < 2; sm++) begin
      stall_mode = sm[0];
      foreach (lens[a]) for (int sx = 0; sx < 2; sx++) foreach (lms[b])
        for (int d = 0; d < 2; d++)
          run_lines(16 * a + 3, lens[a], lens[a] + 3 * sx, lms[b], d[0], 1'b0, 1'b0, -1);
      for (int l = 4; l <= 8; l += 4) for (int s = 8; s <= 12; s += 4)
        for (int m = 0; m <= 2; m += 2)
          run_lines(32, l, s, m, 1'b1, 1'b1, 1'b0, -1);
    end

    stall_mode = 1'b1;
    run_lines(100, 4, 6, 3, 1'b0, 1'b0, 1'b1, -1);   // R2 start while busy ignored
    run_lines(200, 5, 9, 3, 1'b1, 1'b0, 1'b0, 4);    // R10 abort in line mode
    run_lines(16'hFFFE, 3, 4, 1, 1'b0, 1'b0, 1'b0, -1); // R3 address wrap

    run_ring(40, 2, 3, 1'b0, 3);      // area 8, half 4
    stall_mode = 1'b0;
    run_ring(60, 3, 1, 1'b0, 2);      // area 6, half 3
    run_ring(16'hFFF8, 4, 3, 1'b1, 2); // burst ring, area 16, wraps address space
    stall_mode = 1'b1;
    run_ring(8, 5, 1, 1'b0, 2);       // area 10, half 5

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule